// File: doc/BRIEF.md
# USB Device Controller Status Register

This block presents the run-time status of a USB device controller as one 32-bit read word on a simple register bus. Most fields are sampled from the controller every cycle and shown one clock later: core idle, link state, RX FIFO empty, received frame number and connected speed. The block also owns five pieces of state of its own. The first is the halted flag, which gates device event generation. The second is the not-ready flag, raised when the controller leaves hibernation. The third and fourth are the save and restore busy flags. The fifth is a save/restore error bit that software clears by writing 1.

The halted flag drops one cycle after run/stop goes high. It comes back only once run/stop is low, the controller is idle, the lower layer has finished its disconnect, and no events are pending. The not-ready flag covers the state transitions after hibernation exit. It stays set until run/stop has been held high, with the PHY out of suspend, for `NRDY_CYC` consecutive bus clocks. A drop of run/stop or a PHY suspend during that window starts the count again from zero.

The read word is always valid: there is no handshake and no back-pressure on either side. A write strobe with its data word takes effect at the next clock edge.

Top module: `udc_stat_reg`

## Requirements
- R1: During and straight out of reset the read word is 0x00520004. That is: halted (bit 22) = 1, link state (bits 21:18) = 4h, RX FIFO empty (bit 17) = 1, connected speed (bits 2:0) = 4h, every other bit 0.
- R2: One cycle after run/stop is sampled high, halted (bit 22) reads 0.
- R3: With run/stop low, halted sets in the cycle after idle, disconnect-done and no pending events are all sampled true together. While events are pending, halted stays 0.
- R4: The event-allow output is 1 exactly when halted is 0.
- R5: Not-ready (bit 29) sets one cycle after a hibernation-exit pulse seen while hibernation is enabled. It reads 0 one cycle after hibernation is sampled disabled, and exit pulses have no effect while hibernation is disabled.
- R6: Not-ready clears after `NRDY_CYC` (default 256) consecutive cycles with run/stop high and the PHY not suspended. Any cycle of PHY suspend restarts the count.
- R7: A cycle with run/stop low during the count aborts it. A full `NRDY_CYC` cycles are then needed once run/stop returns high.
- R8: Save busy (bit 24) and restore busy (bit 25) set on their start pulse while hibernation is enabled. Each clears on its done pulse, and both read 0 while hibernation is disabled.
- R9: The save/restore error bit (bit 28) sets on an error pulse. A write with data bit 28 = 1 clears it, and a write with bit 28 = 0 leaves it unchanged. If an error pulse and a clearing write arrive in the same cycle, the bit stays set.
- R10: Reserved bits 31:30 and 27:26 read 0. Core idle (bit 23), link state (21:18), RX FIFO empty (17), frame number (16:3) and speed (2:0) show their inputs one cycle after sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run/stop control from the controller |
| ctrl_idle | input | 1 | Controller has drained all data and events |
| disc_done | input | 1 | Lower layer finished disconnect |
| evt_pending | input | 1 | Event count is non-zero |
| hib_en | input | 1 | Hibernation enabled |
| hib_exit | input | 1 | Pulse: controller left hibernation |
| phy_susp | input | 1 | PHY is in suspend |
| save_start | input | 1 | Pulse: save operation begins |
| save_done | input | 1 | Pulse: save operation finished |
| rest_start | input | 1 | Pulse: restore operation begins |
| rest_done | input | 1 | Pulse: restore operation finished |
| sr_err | input | 1 | Pulse: save/restore error |
| rx_empty | input | 1 | RX FIFO empty |
| link_state | input | 4 | Link state code |
| frame_num | input | 14 | Received frame/microframe number |
| conn_speed | input | 3 | Connected speed code |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Status read word |
| evt_allow | output | 1 | Device event generation permitted |

## Verification
On every cycle, the embedded assertions check these rules:
- run/stop always drops halted;
- halted never rises without the full halt condition and never rises while events are pending;
- not-ready only falls after a cycle of run/stop high with the PHY awake;
- disabling hibernation clears the not-ready and save/restore flags;
- the error bit never rises without an error pulse.

The directed scenarios show what a single-cycle property cannot:
- the exact 256-cycle length of the not-ready window;
- the restart after a suspend or after a run/stop drop;
- the reset word;
- the field positions and one-cycle sampling of the mirrored inputs;
- the write-1-to-clear behaviour.

// File: rtl/udc_stat_pkg.sv
package udc_stat_pkg;
  localparam int WORD_W   = 32;
  localparam int LINK_W   = 4;
  localparam int FRAME_W  = 14;
  localparam int SPD_W    = 3;

  localparam int SPD_LSB   = 0;
  localparam int FRAME_LSB = SPD_LSB + SPD_W;
  localparam int RXE_BIT   = FRAME_LSB + FRAME_W;
  localparam int LINK_LSB  = RXE_BIT + 1;
  localparam int HALT_BIT  = LINK_LSB + LINK_W;
  localparam int IDLE_BIT  = HALT_BIT + 1;
  localparam int SSS_BIT   = 24;
  localparam int RSS_BIT   = 25;
  localparam int ERR_BIT   = 28;
  localparam int NRDY_BIT  = 29;

  localparam logic [LINK_W-1:0] LINK_RST = 4'h4;
  localparam logic [SPD_W-1:0]  SPD_RST  = 3'h4;

  typedef struct packed {
    logic               idle;
    logic [LINK_W-1:0]  link;
    logic               rxe;
    logic [FRAME_W-1:0] frame;
    logic [SPD_W-1:0]   spd;
  } obs_t;
endpackage

// File: rtl/udc_halt_ctl.sv
module udc_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic ctrl_idle,
  input  logic disc_done,
  input  logic evt_pending,
  output logic halted
);
  logic halt_cond;
  assign halt_cond = !run_en && ctrl_idle && disc_done && !evt_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          halted <= 1'b1;
    else if (run_en)     halted <= 1'b0;
    else if (halt_cond)  halted <= 1'b1;
  end

  assert_run_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> !halted);
  assert_halt_needs_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(ctrl_idle && disc_done && !evt_pending && !run_en));
  assert_no_halt_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pending && !halted) |=> !halted);
endmodule

// File: rtl/udc_nrdy_timer.sv
module udc_nrdy_timer #(
  parameter int NRDY_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hib_en,
  input  logic hib_exit,
  input  logic run_en,
  input  logic phy_susp,
  output logic nrdy
);
  localparam int CNT_W = $clog2(NRDY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NRDY_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             counting;
  assign counting = nrdy && run_en && !phy_susp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrdy <= 1'b0;
      cnt  <= '0;
    end else if (!hib_en) begin
      nrdy <= 1'b0;
      cnt  <= '0;
    end else if (hib_exit) begin
      nrdy <= 1'b1;
      cnt  <= '0;
    end else if (counting) begin
      if (cnt == CNT_LAST) begin
        nrdy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  assert_hib_off_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hib_en |=> !nrdy);
  assert_exit_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_en && hib_exit) |=> nrdy);
  assert_fall_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nrdy) && $past(hib_en)) |-> $past(run_en && !phy_susp));
  assert_drop_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nrdy && hib_en && !run_en) |=> nrdy);
endmodule

// File: rtl/udc_hib_flags.sv
import udc_stat_pkg::*;

module udc_hib_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hib_en,
  input  logic        save_start,
  input  logic        save_done,
  input  logic        rest_start,
  input  logic        rest_done,
  input  logic        sr_err,
  input  logic        wr_en,
  input  logic        wr_clr,
  output logic        save_busy,
  output logic        rest_busy,
  output logic        err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_busy <= 1'b0;
      rest_busy <= 1'b0;
    end else if (!hib_en) begin
      save_busy <= 1'b0;
      rest_busy <= 1'b0;
    end else begin
      if (save_start)     save_busy <= 1'b1;
      else if (save_done) save_busy <= 1'b0;
      if (rest_start)     rest_busy <= 1'b1;
      else if (rest_done) rest_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                err <= 1'b0;
    else if (sr_err)           err <= 1'b1;
    else if (wr_en && wr_clr)  err <= 1'b0;
  end

  assert_hib_off_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hib_en |=> (!save_busy && !rest_busy));
  assert_save_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_en && save_done && !save_start) |=> !save_busy);
  assert_err_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(sr_err));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(wr_en && wr_clr)) |=> err);
endmodule

// File: rtl/udc_stat_reg.sv
import udc_stat_pkg::*;

module udc_stat_reg #(
  parameter int NRDY_CYC = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 ctrl_idle,
  input  logic                 disc_done,
  input  logic                 evt_pending,
  input  logic                 hib_en,
  input  logic                 hib_exit,
  input  logic                 phy_susp,
  input  logic                 save_start,
  input  logic                 save_done,
  input  logic                 rest_start,
  input  logic                 rest_done,
  input  logic                 sr_err,
  input  logic                 rx_empty,
  input  logic [LINK_W-1:0]    link_state,
  input  logic [FRAME_W-1:0]   frame_num,
  input  logic [SPD_W-1:0]     conn_speed,
  input  logic                 wr_en,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 evt_allow
);
  obs_t obs_q;
  logic halted, nrdy, save_busy, rest_busy, err;
  logic unused_wr;
  assign unused_wr = ^{wr_data[WORD_W-1:ERR_BIT+1], wr_data[ERR_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obs_q.idle  <= 1'b0;
      obs_q.link  <= LINK_RST;
      obs_q.rxe   <= 1'b1;
      obs_q.frame <= '0;
      obs_q.spd   <= SPD_RST;
    end else begin
      obs_q.idle  <= ctrl_idle;
      obs_q.link  <= link_state;
      obs_q.rxe   <= rx_empty;
      obs_q.frame <= frame_num;
      obs_q.spd   <= conn_speed;
    end
  end

  udc_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ctrl_idle(ctrl_idle),
    .disc_done(disc_done), .evt_pending(evt_pending), .halted(halted)
  );

  udc_nrdy_timer #(.NRDY_CYC(NRDY_CYC)) u_nrdy (
    .clk(clk), .rst_n(rst_n), .hib_en(hib_en), .hib_exit(hib_exit),
    .run_en(run_en), .phy_susp(phy_susp), .nrdy(nrdy)
  );

  udc_hib_flags u_flags (
    .clk(clk), .rst_n(rst_n), .hib_en(hib_en),
    .save_start(save_start), .save_done(save_done),
    .rest_start(rest_start), .rest_done(rest_done),
    .sr_err(sr_err), .wr_en(wr_en), .wr_clr(wr_data[ERR_BIT]),
    .save_busy(save_busy), .rest_busy(rest_busy), .err(err)
  );

  always_comb begin
    rd_data = '0;
    rd_data[NRDY_BIT] = nrdy;
    rd_data[ERR_BIT]  = err;
    rd_data[RSS_BIT]  = rest_busy;
    rd_data[SSS_BIT]  = save_busy;
    rd_data[IDLE_BIT] = obs_q.idle;
    rd_data[HALT_BIT] = halted;
    rd_data[LINK_LSB +: LINK_W]   = obs_q.link;
    rd_data[RXE_BIT]  = obs_q.rxe;
    rd_data[FRAME_LSB +: FRAME_W] = obs_q.frame;
    rd_data[SPD_LSB +: SPD_W]     = obs_q.spd;
  end

  assign evt_allow = !halted;

  assert_gate_follows_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> evt_allow);
endmodule

// File: tb/sim_udc_stat_reg.sv
module sim_udc_stat_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 0, ctrl_idle = 0, disc_done = 0, evt_pending = 0;
  logic hib_en = 0, hib_exit = 0, phy_susp = 0;
  logic save_start = 0, save_done = 0, rest_start = 0, rest_done = 0, sr_err = 0;
  logic rx_empty = 0;
  logic [3:0]  link_state = 0;
  logic [13:0] frame_num = 0;
  logic [2:0]  conn_speed = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        evt_allow;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  udc_stat_reg u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ctrl_idle(ctrl_idle),
    .disc_done(disc_done), .evt_pending(evt_pending), .hib_en(hib_en),
    .hib_exit(hib_exit), .phy_susp(phy_susp), .save_start(save_start),
    .save_done(save_done), .rest_start(rest_start), .rest_done(rest_done),
    .sr_err(sr_err), .rx_empty(rx_empty), .link_state(link_state),
    .frame_num(frame_num), .conn_speed(conn_speed), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .evt_allow(evt_allow)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 reset word", rd_data, 32'h0052_0004);
    chk("R4 gate in reset", {31'd0, evt_allow}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_mirror;
    ctrl_idle = 1; link_state = 4'h9; rx_empty = 0; frame_num = 14'h2A5B; conn_speed = 3'd1;
    step(1);
    chk("R10 mirror fields", rd_data,
        (32'd1 << 23) | (32'd1 << 22) | (32'h9 << 18) | (32'h2A5B << 3) | 32'd1);
    chk("R10 reserved zero", rd_data & 32'hCC00_0000, 32'd0);
    link_state = 4'h0; frame_num = 14'h3FFF; conn_speed = 3'd0; rx_empty = 1; ctrl_idle = 0;
    step(1);
    chk("R10 second pattern", rd_data & 32'h00BF_FFFF, (32'h3FFF << 3) | (32'd1 << 17));
  endtask

  task automatic t_halt;
    run_en = 1;
    step(1);
    chk("R2 halted clear", {31'd0, rd_data[22]}, 32'd0);
    chk("R4 gate open", {31'd0, evt_allow}, 32'd1);
    run_en = 0; ctrl_idle = 1; disc_done = 1; evt_pending = 1;
    step(3);
    chk("R3 pending blocks halt", {31'd0, rd_data[22]}, 32'd0);
    evt_pending = 0; disc_done = 0;
    step(2);
    chk("R3 no disconnect no halt", {31'd0, rd_data[22]}, 32'd0);
    disc_done = 1;
    step(1);
    chk("R3 halt sets", {31'd0, rd_data[22]}, 32'd1);
    chk("R4 gate closed", {31'd0, evt_allow}, 32'd0);
    ctrl_idle = 0; disc_done = 0;
  endtask

  task automatic exit_hib;
    hib_en = 1; hib_exit = 1;
    step(1);
    hib_exit = 0;
    chk("R5 exit sets not-ready", {31'd0, rd_data[29]}, 32'd1);
  endtask

  task automatic t_nrdy_basic;
    exit_hib();
    run_en = 1;
    step(255);
    chk("R6 still not-ready at 255", {31'd0, rd_data[29]}, 32'd1);
    step(1);
    chk("R6 clear at 256", {31'd0, rd_data[29]}, 32'd0);
    run_en = 0;
  endtask

  task automatic t_nrdy_susp;
    exit_hib();
    run_en = 1; phy_susp = 1;
    step(300);
    chk("R6 held during suspend", {31'd0, rd_data[29]}, 32'd1);
    phy_susp = 0;
    step(100);
    phy_susp = 1;
    step(1);
    phy_susp = 0;
    step(255);
    chk("R6 restart after suspend", {31'd0, rd_data[29]}, 32'd1);
    step(1);
    chk("R6 clear after full window", {31'd0, rd_data[29]}, 32'd0);
    run_en = 0;
  endtask

  task automatic t_nrdy_abort;
    exit_hib();
    run_en = 1;
    step(200);
    run_en = 0;
    step(1);
    chk("R7 drop keeps not-ready", {31'd0, rd_data[29]}, 32'd1);
    run_en = 1;
    step(255);
    chk("R7 count restarted", {31'd0, rd_data[29]}, 32'd1);
    step(1);
    chk("R7 clear after restart", {31'd0, rd_data[29]}, 32'd0);
    run_en = 0;
  endtask

  task automatic t_nrdy_hibdis;
    exit_hib();
    hib_en = 0;
    step(1);
    chk("R5 disable clears", {31'd0, rd_data[29]}, 32'd0);
    hib_exit = 1;
    step(1);
    hib_exit = 0;
    step(1);
    chk("R5 exit ignored when disabled", {31'd0, rd_data[29]}, 32'd0);
  endtask

  task automatic t_savrest;
    hib_en = 1; save_start = 1;
    step(1);
    save_start = 0;
    chk("R8 save busy set", {31'd0, rd_data[24]}, 32'd1);
    save_done = 1;
    step(1);
    save_done = 0;
    chk("R8 save busy clear", {31'd0, rd_data[24]}, 32'd0);
    rest_start = 1;
    step(1);
    rest_start = 0;
    chk("R8 restore busy set", {31'd0, rd_data[25]}, 32'd1);
    rest_done = 1;
    step(1);
    rest_done = 0;
    chk("R8 restore busy clear", {31'd0, rd_data[25]}, 32'd0);
    rest_start = 1;
    step(1);
    rest_start = 0;
    hib_en = 0;
    step(1);
    chk("R8 restore zero when disabled", {31'd0, rd_data[25]}, 32'd0);
    save_start = 1;
    step(1);
    save_start = 0;
    chk("R8 save ignored when disabled", {31'd0, rd_data[24]}, 32'd0);
  endtask

  task automatic t_err;
    sr_err = 1;
    step(1);
    sr_err = 0;
    chk("R9 error set", {31'd0, rd_data[28]}, 32'd1);
    wr_en = 1; wr_data = ~(32'd1 << 28);
    step(1);
    chk("R9 write zero keeps", {31'd0, rd_data[28]}, 32'd1);
    wr_data = 32'd1 << 28;
    step(1);
    wr_en = 0;
    chk("R9 write one clears", {31'd0, rd_data[28]}, 32'd0);
    sr_err = 1; wr_en = 1;
    step(1);
    sr_err = 0; wr_en = 0; wr_data = 0;
    chk("R9 set wins over clear", {31'd0, rd_data[28]}, 32'd1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_mirror();
    t_halt();
    t_nrdy_basic();
    t_nrdy_susp();
    t_nrdy_abort();
    t_nrdy_hibdis();
    t_savrest();
    t_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule